// File: doc/BRIEF.md
# Multi-Lane Word Lock Monitor

This block tracks word alignment for every lane of a multi-lane serial receiver that carries 67-bit words. Each word has a 3-bit sync header. For each lane the block takes a word-valid strobe and the header of the current word. It declares word lock once it has seen a long enough unbroken run of legal headers. Once locked, it watches the error rate and gives up lock when too many headers inside a sliding window of words are illegal.

A separate stage outside this block finds the metaframe boundary and recovers the scrambler seed. That stage supplies one raw frame-sync indication per lane. The block passes each indication on as that lane's sync lock, but only while the lane holds word lock, so within a lane sync lock always follows word lock. Two registered flags report whether every lane is word locked and whether every lane is sync locked.

A reset request input starts an internal initialisation sequence of a fixed number of clock cycles. While that sequence runs, every lane is held cleared and its inputs are ignored. Lock acquisition starts only after the sequence has finished. A synchronous reset also starts the same sequence.

Top module: `lane_lock_monitor`

## Requirements
- R1: A header is legal when its two low bits are 2'b01 or 2'b10. The values 2'b00 and 2'b11 are illegal. Bit 2 (the inversion flag) has no effect on legality.
- R2: An unlocked lane sets its `word_lock` bit on the clock edge that samples the 64th consecutive valid legal header.
- R3: Before lock, an illegal valid header resets that lane's run count to zero. A cycle with `word_vld` low neither adds to the run nor breaks it.
- R4: A locked lane counts illegal headers over windows of 64 valid words. On the 16th illegal header in one window it clears `word_lock`. At the end of each window the error count restarts from zero.
- R5: A lane's `sync_lock` bit is `frame_sync_raw` registered by one cycle, and only while that lane holds word lock. When the lane is unlocked, `frame_sync_raw` has no effect and `sync_lock` stays 0.
- R6: On the edge where a lane loses word lock, its `sync_lock` bit is cleared together with `word_lock`.
- R7: `all_word_lock` equals the AND of all `word_lock` bits, delayed by one clock cycle.
- R8: `all_sync_lock` equals the AND of all `sync_lock` bits, delayed by one clock cycle.
- R9: `rst` clears all outputs and counters. `rst` or a `reset_req` pulse starts an initialisation sequence of INIT_CYCLES (default 8) clock edges. During that sequence all lanes are held cleared and their inputs are ignored. A new request during the sequence restarts it.
- R10: Lanes are independent. The headers, strobes and frame-sync input of one lane never change another lane's lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Pulse that starts the internal initialisation sequence |
| word_vld | input | NUM_LANES | Per-lane strobe: a word is present this cycle |
| hdr_in | input | 3*NUM_LANES | Per-lane 3-bit sync header; lane i uses bits [3i+2:3i] |
| frame_sync_raw | input | NUM_LANES | Per-lane raw metaframe/seed sync indication |
| word_lock | output | NUM_LANES | Per-lane word lock |
| sync_lock | output | NUM_LANES | Per-lane sync lock, qualified by word lock |
| all_word_lock | output | 1 | Every lane is word locked (registered) |
| all_sync_lock | output | 1 | Every lane is sync locked (registered) |

## Verification
The lanes are driven with different patterns at the same time. One lane has a single illegal header just before its run completes, which shows whether the run really restarts. One cycles through all legal codes with bit 2 flipping, which shows that the inversion flag is ignored. One has gaps in its valid strobe, which shows that idle cycles neither count nor reset. One has a periodic illegal header, so it never locks. After lock, a burst of 15 errors must not drop the lane, while a longer burst must drop it. Frame-sync toggling, reset requests during and after lock, and requests during the initialisation sequence separate the ordering and masking rules from a plain pass-through.

// File: rtl/lane_lock_pkg.sv
package lane_lock_pkg;
  localparam int HDR_W = 3;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lane_state_e;

  // legal when the two low bits differ; bit 2 is the inversion flag
  function automatic logic hdr_is_legal(input logic [HDR_W-1:0] h);
    return h[1] ^ h[0];
  endfunction
endpackage

// File: rtl/init_sequencer.sv
module init_sequencer #(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic busy
);
  localparam int CW = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_req) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  req_starts_seq_chk: assert property (@(posedge clk) disable iff (rst)
    start_req |=> busy);
endmodule

// File: rtl/lane_word_lock.sv
module lane_word_lock
  import lane_lock_pkg::*;
#(
  parameter int LOCK_RUN  = 64,
  parameter int WINDOW    = 64,
  parameter int BAD_LIMIT = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             hdr_vld,
  input  logic [HDR_W-1:0] hdr,
  input  logic             fsync_raw,
  output logic             word_lock,
  output logic             sync_lock
);
  localparam int MAXC = (LOCK_RUN > WINDOW) ? LOCK_RUN : WINDOW;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW - 1);
  localparam logic [CW-1:0] BAD_LAST = CW'(BAD_LIMIT - 1);

  lane_state_e   state_q;
  logic [CW-1:0] good_q, win_q, bad_q;
  logic          sync_q;
  logic          legal, drop;

  always_comb begin
    legal = hdr_is_legal(hdr);
    drop  = (state_q == ST_LOCK) && hdr_vld && !legal && (bad_q == BAD_LAST);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= ST_HUNT;
      good_q  <= '0;
      win_q   <= '0;
      bad_q   <= '0;
      sync_q  <= 1'b0;
    end else begin
      sync_q <= (state_q == ST_LOCK) && !drop && fsync_raw;
      case (state_q)
        ST_HUNT: begin
          if (hdr_vld) begin
            if (!legal) begin
              good_q <= '0;
            end else if (good_q == RUN_LAST) begin
              state_q <= ST_LOCK;
              good_q  <= '0;
              win_q   <= '0;
              bad_q   <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
        end
        default: begin
          if (hdr_vld) begin
            if (drop) begin
              state_q <= ST_HUNT;
              win_q   <= '0;
              bad_q   <= '0;
            end else if (win_q == WIN_LAST) begin
              win_q <= '0;
              bad_q <= '0;
            end else begin
              win_q <= win_q + 1'b1;
              if (!legal) bad_q <= bad_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign word_lock = (state_q == ST_LOCK);
  assign sync_lock = sync_q;

  // R2
  lock_on_legal_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(word_lock) |-> $past(hdr_vld && hdr_is_legal(hdr)));
  // R4
  drop_on_illegal_chk: assert property (@(posedge clk) disable iff (clr)
    ($fell(word_lock) && !$past(clr)) |-> $past(hdr_vld && !hdr_is_legal(hdr)));
  // R5
  sync_after_word_chk: assert property (@(posedge clk) disable iff (clr)
    sync_lock |-> word_lock);
  // R6
  drop_clears_sync_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(word_lock) |-> !sync_lock);
endmodule

// File: rtl/lock_aggregator.sv
module lock_aggregator #(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] word_vec,
  input  logic [NUM_LANES-1:0] sync_vec,
  output logic                 all_word,
  output logic                 all_sync
);
  always_ff @(posedge clk) begin
    if (rst) begin
      all_word <= 1'b0;
      all_sync <= 1'b0;
    end else begin
      all_word <= &word_vec;
      all_sync <= &sync_vec;
    end
  end

  // R7
  all_word_chk: assert property (@(posedge clk) disable iff (rst)
    all_word |-> $past(&word_vec));
  // R8
  all_sync_chk: assert property (@(posedge clk) disable iff (rst)
    all_sync |-> $past(&sync_vec));
endmodule

// File: rtl/lane_lock_monitor.sv
module lane_lock_monitor
  import lane_lock_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int LOCK_RUN    = 64,
  parameter int WINDOW      = 64,
  parameter int BAD_LIMIT   = 16,
  parameter int INIT_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reset_req,
  input  logic [NUM_LANES-1:0]       word_vld,
  input  logic [NUM_LANES*HDR_W-1:0] hdr_in,
  input  logic [NUM_LANES-1:0]       frame_sync_raw,
  output logic [NUM_LANES-1:0]       word_lock,
  output logic [NUM_LANES-1:0]       sync_lock,
  output logic                       all_word_lock,
  output logic                       all_sync_lock
);
  logic busy;
  logic lane_clr;

  init_sequencer #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (reset_req),
    .busy      (busy)
  );

  assign lane_clr = rst | busy;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lane_word_lock #(
      .LOCK_RUN  (LOCK_RUN),
      .WINDOW    (WINDOW),
      .BAD_LIMIT (BAD_LIMIT)
    ) u_lane (
      .clk       (clk),
      .clr       (lane_clr),
      .hdr_vld   (word_vld[i]),
      .hdr       (hdr_in[i*HDR_W +: HDR_W]),
      .fsync_raw (frame_sync_raw[i]),
      .word_lock (word_lock[i]),
      .sync_lock (sync_lock[i])
    );
  end

  lock_aggregator #(.NUM_LANES(NUM_LANES)) u_agg (
    .clk      (clk),
    .rst      (rst),
    .word_vec (word_lock),
    .sync_vec (sync_lock),
    .all_word (all_word_lock),
    .all_sync (all_sync_lock)
  );

  // R9
  init_masks_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (word_lock == '0));
endmodule

// File: tb/lane_lock_monitor_bench.sv
module lane_lock_monitor_bench;
  localparam int N    = 4;
  localparam int INIT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reset_req = 1'b0;
  logic [N-1:0] vld = '0;
  logic [N-1:0] fs = '0;
  logic [2:0] h_a [N];
  logic [N*3-1:0] hdr_bus;
  logic [N-1:0] wl, sl;
  logic aw, as_;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) hdr_bus[i*3 +: 3] = h_a[i];
  end

  lane_lock_monitor #(.NUM_LANES(N), .INIT_CYCLES(INIT)) u_lane_lock_monitor (
    .clk(clk), .rst(rst), .reset_req(reset_req), .word_vld(vld),
    .hdr_in(hdr_bus), .frame_sync_raw(fs), .word_lock(wl), .sync_lock(sl),
    .all_word_lock(aw), .all_sync_lock(as_)
  );

  // behavioural reference model
  int m_good [N];
  int m_win [N];
  int m_bad [N];
  bit m_wl [N];
  bit m_sl [N];
  bit m_aw, m_as;
  int m_busy;

  always @(posedge clk) begin
    bit aw_n, as_n, legal, drop;
    aw_n = 1; as_n = 1;
    for (int i = 0; i < N; i++) begin aw_n &= m_wl[i]; as_n &= m_sl[i]; end
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_good[i] = 0; m_win[i] = 0; m_bad[i] = 0; m_wl[i] = 0; m_sl[i] = 0;
      end
      m_aw = 0; m_as = 0; m_busy = INIT;
    end else begin
      if (m_busy > 0) begin
        for (int i = 0; i < N; i++) begin
          m_good[i] = 0; m_win[i] = 0; m_bad[i] = 0; m_wl[i] = 0; m_sl[i] = 0;
        end
        m_busy--;
      end else begin
        for (int i = 0; i < N; i++) begin
          legal = (h_a[i][1:0] == 2'b01) || (h_a[i][1:0] == 2'b10);
          if (!m_wl[i]) begin
            m_sl[i] = 0;
            if (vld[i]) begin
              if (legal) begin
                m_good[i]++;
                if (m_good[i] == 64) begin
                  m_wl[i] = 1; m_good[i] = 0; m_win[i] = 0; m_bad[i] = 0;
                end
              end else m_good[i] = 0;
            end
          end else begin
            drop = 0;
            if (vld[i]) begin
              if (!legal) m_bad[i]++;
              if (m_bad[i] == 16) begin
                drop = 1; m_wl[i] = 0; m_win[i] = 0; m_bad[i] = 0;
              end else begin
                m_win[i]++;
                if (m_win[i] == 64) begin m_win[i] = 0; m_bad[i] = 0; end
              end
            end
            m_sl[i] = !drop && fs[i];
          end
        end
      end
      if (reset_req) m_busy = INIT;
      m_aw = aw_n; m_as = as_n;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 0;
  bit done = 0;
  string phase = "R9";

  always @(negedge clk) begin
    logic [N-1:0] ew, es;
    if (chk_en) begin
      for (int i = 0; i < N; i++) begin ew[i] = m_wl[i]; es[i] = m_sl[i]; end
      n_chk++;
      if (wl !== ew || sl !== es || aw !== m_aw || as_ !== m_as) begin
        n_fail++;
        $display("FAIL %s t=%0t actual wl=%b sl=%b aw=%b as=%b expected wl=%b sl=%b aw=%b as=%b",
                 phase, $time, wl, sl, aw, as_, ew, es, m_aw, m_as);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_all(input logic v, input logic [2:0] h);
    for (int i = 0; i < N; i++) begin vld[i] = v; h_a[i] = h; end
  endtask

  task automatic pulse_req();
    reset_req = 1'b1; tick(); reset_req = 1'b0;
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired in phase %s", phase);
      report();
    end
  end

  initial begin
    set_all(1'b0, 3'b001);
    repeat (3) tick();
    // R9: reset state
    chk("R9 reset outputs", {wl, sl, aw, as_}, 0);
    chk_en = 1;
    // R9: legal words during the init sequence are ignored
    set_all(1'b1, 3'b001); fs = '1;
    rst = 1'b0;
    repeat (64) tick();
    chk("R9 init words ignored", wl, 0);
    repeat (INIT) tick();
    chk("R2 lock after full run", wl, 4'hF);

    // restart, request again inside the sequence
    phase = "R9";
    pulse_req();
    repeat (3) tick();
    pulse_req();
    set_all(1'b0, 3'b001);
    repeat (INIT + 2) tick();
    chk("R9 cleared by request", {wl, sl, aw, as_}, 0);

    // mixed lane patterns
    phase = "R1 R3 R10";
    for (int c = 0; c < 200; c++) begin
      vld[0] = 1; h_a[0] = (c == 62) ? 3'b111 : 3'b010;
      vld[1] = 1; h_a[1] = (c % 4 == 0) ? 3'b001 : (c % 4 == 1) ? 3'b110 :
                           (c % 4 == 2) ? 3'b101 : 3'b010;
      vld[2] = (c % 2 == 0); h_a[2] = (c % 2 == 0) ? 3'b001 : 3'b000;
      vld[3] = 1; h_a[3] = (c % 40 == 39) ? ((c % 80 == 39) ? 3'b000 : 3'b111) : 3'b110;
      fs = '1;
      if (c == 63) chk("R2 lane1 at 63 words", wl[1], 0);
      if (c == 64) chk("R1 lane1 locked", wl[1], 1);
      if (c == 126) chk("R3 lane0 restarted run", wl[0], 0);
      tick();
    end
    chk("R10 lanes 0-2 locked, lane 3 not", wl, 4'b0111);
    chk("R5 sync follows lock", sl, 4'b0111);
    chk("R7 not all locked", aw, 0);

    phase = "R7 R8";
    set_all(1'b1, 3'b010);
    repeat (66) tick();
    chk("R7 all word locked", aw, 1);
    chk("R8 all sync locked", as_, 1);

    phase = "R5";
    for (int c = 0; c < 24; c++) begin
      fs = 4'(c * 5);
      tick();
    end
    fs = '1;
    tick(); tick();
    chk("R8 sync back", as_, 1);

    phase = "R4";
    for (int c = 0; c < 15; c++) begin h_a[0] = 3'b011; tick(); end
    h_a[0] = 3'b001;
    for (int c = 0; c < 200; c++) begin
      h_a[1] = (c % 5 == 0) ? 3'b100 : 3'b001;
      tick();
    end
    h_a[1] = 3'b001;
    chk("R4 15 errors keep lock", wl, 4'hF);
    phase = "R4 R6";
    for (int c = 0; c < 40; c++) begin h_a[0] = 3'b000; tick(); end
    chk("R4 burst drops lane0", wl[0], 0);
    chk("R6 sync cleared", sl[0], 0);
    chk("R7 aggregate dropped", aw, 0);
    h_a[0] = 3'b001;
    repeat (70) tick();

    phase = "R9";
    pulse_req();
    tick();
    chk("R9 request clears locks", {wl, sl}, 0);
    repeat (INIT + 70) tick();
    rst = 1'b1; tick(); rst = 1'b0; tick();
    chk("R9 rst clears", {wl, sl, aw, as_}, 0);
    repeat (20) tick();

    done = 1;
    report();
  end
endmodule